// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards the frequency-select register of a programmable clock generator. Software changes the output frequency by writing a new select code through a small register write port. When the watchdog is armed, every real change of the select code starts a countdown. If software does not disarm the watchdog before the count runs out, the block does several things. It sets a sticky time-out flag. It forces the select code to a fixed recovery value. It locks the select register so that software cannot change it. It can also emit a system reset pulse.

A second, independent option emits the same kind of reset pulse after every frequency change. This lets the rest of the system restart on the new clock. The lock is released only by clearing the watchdog enable. Clearing the enable also stops the counter and reloads it.

Register map (address on `addr_i`): address 0 holds the select code in bits [SEL_W-1:0]. Address 1 is control/status: bit 0 watchdog enable, bit 1 reset-on-time-out enable, bit 2 reset-on-change enable, bit 3 time-out flag (write 1 to clear), bit 4 lock flag (read-only). Unused bits and addresses read 0.

Top module: `freq_wdog_top`

## Requirements
- R1: After reset the select code is 0, every control and status bit at address 1 reads 0, and `sys_rst_o` is low.
- R2: While unlocked, a write to address 0 puts wdata[SEL_W-1:0] on `freq_sel_o` from the next rising edge onward, and the code reads back at address 0.
- R3: While the enable (address 1 bit 0) is 0, the counter is held at its reload value, and no time-out ever occurs, however many frequency changes are made.
- R4: With the enable at 1, only a write to address 0 whose value differs from the current code starts the count; a same-value write does not. The time-out takes effect on the (WD_RELOAD+1)-th rising edge after the edge of the starting write. From that edge, bit 3 and bit 4 of address 1 read 1 and `freq_sel_o` equals RECOVERY_SEL.
- R5: A further code change made before expiry restarts the count from WD_RELOAD.
- R6: Writing address 1 with bit 3 set clears the time-out flag. Writing bit 3 as 0 leaves the flag unchanged. A time-out in the same cycle as a clear wins.
- R7: While locked, writes to address 0 are ignored, and `freq_sel_o` keeps the recovery code.
- R8: Clearing the enable releases the lock. Bit 4 reads 0 from the second rising edge after the clearing write, and address 0 is writable again.
- R9: With bit 1 set, a time-out drives `sys_rst_o` high for exactly RST_LEN cycles. The pulse starts at the same edge that sets the flag.
- R10: With bit 2 set, every code change drives `sys_rst_o` high for exactly RST_LEN cycles, starting at the edge of the write. A same-value write gives no pulse.
- R11: With bits 1 and 2 clear, neither time-outs nor code changes raise `sys_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address, for both reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| freq_sel_o | output | SEL_W (4) | Frequency-select code to the synthesizer |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The bench builds the block with WD_RELOAD=12, RST_LEN=3 and RECOVERY_SEL=5. The short reload lets random write traffic reach real time-outs, lock entry, clears racing an expiry, and unlocks many times within a few thousand cycles. The 3-cycle pulse lets a new trigger land while a pulse is still running. A recovery code of 5 lies outside the random select range of 0 to 3, so a forced load can never be mistaken for a software write.

// File: rtl/freq_wdog_pkg.sv
package freq_wdog_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_SEL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd1;

  // control/status bit positions at ADDR_CTL
  localparam int CTL_EN   = 0;
  localparam int CTL_RTO  = 1;
  localparam int CTL_RFC  = 2;
  localparam int CTL_STAT = 3;
  localparam int CTL_LOCK = 4;

  typedef struct packed {
    logic rst_fc_en;
    logic rst_to_en;
    logic wd_en;
  } ctl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import freq_wdog_pkg::*;
#(
  parameter int          SEL_W        = 4,
  parameter int unsigned RECOVERY_SEL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic [SEL_W-1:0]  sel_o,
  output ctl_t              ctl_o,
  output logic              status_o,
  output logic              locked_o,
  output logic              fc_evt_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [SEL_W-1:0] REC = SEL_W'(RECOVERY_SEL);

  logic wr_sel, wr_ctl;
  logic unused_wdata;

  assign wr_sel       = we_i && (addr_i == ADDR_SEL);
  assign wr_ctl       = we_i && (addr_i == ADDR_CTL);
  assign unused_wdata = ^wdata_i;
  // only a real value change counts as a frequency change
  assign fc_evt_o     = wr_sel && !locked_o && (wdata_i[SEL_W-1:0] != sel_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= '0;
      ctl_o    <= '0;
      status_o <= 1'b0;
      locked_o <= 1'b0;
    end else begin
      if (expire_i)      sel_o <= REC;
      else if (fc_evt_o) sel_o <= wdata_i[SEL_W-1:0];

      if (wr_ctl) begin
        ctl_o.wd_en     <= wdata_i[CTL_EN];
        ctl_o.rst_to_en <= wdata_i[CTL_RTO];
        ctl_o.rst_fc_en <= wdata_i[CTL_RFC];
      end

      if (expire_i)                          status_o <= 1'b1;
      else if (wr_ctl && wdata_i[CTL_STAT]) status_o <= 1'b0;

      if (expire_i)          locked_o <= 1'b1;
      else if (!ctl_o.wd_en) locked_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_SEL: rdata_o[SEL_W-1:0] = sel_o;
      ADDR_CTL: begin
        rdata_o[CTL_EN]   = ctl_o.wd_en;
        rdata_o[CTL_RTO]  = ctl_o.rst_to_en;
        rdata_o[CTL_RFC]  = ctl_o.rst_fc_en;
        rdata_o[CTL_STAT] = status_o;
        rdata_o[CTL_LOCK] = locked_o;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned RELOAD = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int          CW   = $clog2(RELOAD + 1);
  localparam logic [CW-1:0] LOAD = CW'(RELOAD);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o = en_i && run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD;
      run_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int          PW    = $clog2(LEN + 1);
  localparam logic [PW-1:0] PLOAD = PW'(LEN);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (trig_i)        cnt_q <= PLOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/freq_wdog_top.sv
module freq_wdog_top
  import freq_wdog_pkg::*;
#(
  parameter int          SEL_W        = 4,
  parameter int unsigned WD_RELOAD    = 1000,
  parameter int unsigned RST_LEN      = 4,
  parameter int unsigned RECOVERY_SEL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  freq_sel_o,
  output logic              sys_rst_o
);
  ctl_t ctl;
  logic status, locked, fc_evt, expire, rst_trig;

  wdog_regs #(
    .SEL_W       (SEL_W),
    .RECOVERY_SEL(RECOVERY_SEL)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .expire_i(expire),
    .sel_o   (freq_sel_o),
    .ctl_o   (ctl),
    .status_o(status),
    .locked_o(locked),
    .fc_evt_o(fc_evt),
    .rdata_o (rdata_o)
  );

  wdog_timer #(
    .RELOAD(WD_RELOAD)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctl.wd_en),
    .restart_i(fc_evt),
    .expire_o (expire)
  );

  assign rst_trig = (expire && ctl.rst_to_en) || (fc_evt && ctl.rst_fc_en);

  rst_pulse_gen #(
    .LEN(RST_LEN)
  ) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (rst_trig),
    .pulse_o(sys_rst_o)
  );
endmodule

// File: rtl/freq_wdog_chk.sv
module freq_wdog_chk
  import freq_wdog_pkg::*;
#(
  parameter int          SEL_W        = 4,
  parameter int unsigned RECOVERY_SEL = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              clr_bit,
  input logic [SEL_W-1:0]  freq_sel_o,
  input logic              sys_rst_o,
  input logic              expire,
  input logic              locked,
  input logic              status,
  input logic              wd_en,
  input logic              rst_to_en
);
  // R4
  timeout_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (freq_sel_o == SEL_W'(RECOVERY_SEL)) && status && locked);

  // R7
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && we_i && addr_i == ADDR_SEL) |=> $stable(freq_sel_o));

  // R8
  unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en |=> !locked);

  // R3
  no_expire_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en |=> !expire);

  // R6
  status_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CTL && clr_bit && !expire) |=> !status);

  // R9
  to_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && rst_to_en) |=> sys_rst_o);
endmodule

bind freq_wdog_top freq_wdog_chk #(
  .SEL_W       (SEL_W),
  .RECOVERY_SEL(RECOVERY_SEL)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .clr_bit   (wdata_i[freq_wdog_pkg::CTL_STAT]),
  .freq_sel_o(freq_sel_o),
  .sys_rst_o (sys_rst_o),
  .expire    (expire),
  .locked    (locked),
  .status    (status),
  .wd_en     (ctl.wd_en),
  .rst_to_en (ctl.rst_to_en)
);

// File: tb/tb_freq_wdog_top.sv
module tb_freq_wdog_top;
  localparam int SEL_W = 4;
  localparam int RL    = 12;
  localparam int LEN   = 3;
  localparam int REC   = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] freq_sel_o;
  logic       sys_rst_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // bench-side expected state
  logic [3:0] m_sel;
  logic m_en, m_rto, m_rfc, m_st, m_lk, m_run;
  int m_cnt, m_pc;

  always #2.5 clk_i = ~clk_i;

  freq_wdog_top #(
    .SEL_W(SEL_W), .WD_RELOAD(RL), .RST_LEN(LEN), .RECOVERY_SEL(REC)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .freq_sel_o(freq_sel_o),
    .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {4'd0, m_sel};
      2'd1: return {3'd0, m_lk, m_st, m_rfc, m_rto, m_en};
      default: return 8'd0;
    endcase
  endfunction

  function automatic int rd(input logic [1:0] a);
    return 0;
  endfunction

  task automatic model_reset();
    m_sel = '0; m_en = 0; m_rto = 0; m_rfc = 0; m_st = 0; m_lk = 0;
    m_run = 0; m_cnt = RL; m_pc = 0;
  endtask

  // drives at negedge, advances one edge, returns at next negedge
  task automatic step(input bit we, input logic [1:0] a, input logic [7:0] d);
    bit ex, fc, trig;
    we_i = we; addr_i = a; wdata_i = d;
    ex = m_en && m_run && (m_cnt == 0);
    fc = we && a == 2'd0 && !m_lk && (d[3:0] != m_sel);
    trig = (ex && m_rto) || (fc && m_rfc);
    @(posedge clk_i);
    if (!m_en) begin m_cnt = RL; m_run = 0; end
    else if (fc) begin m_cnt = RL; m_run = 1; end
    else if (m_run) begin
      if (m_cnt == 0) m_run = 0; else m_cnt--;
    end
    m_lk = ex ? 1'b1 : (!m_en ? 1'b0 : m_lk);
    m_sel = ex ? 4'(REC) : (fc ? d[3:0] : m_sel);
    m_st = ex ? 1'b1 : ((we && a == 2'd1 && d[3]) ? 1'b0 : m_st);
    if (we && a == 2'd1) begin m_en = d[0]; m_rto = d[1]; m_rfc = d[2]; end
    m_pc = trig ? LEN : (m_pc != 0 ? m_pc - 1 : 0);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic read(input logic [1:0] a, output logic [7:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  task automatic check_model(input string tag);
    logic [7:0] v;
    chk(freq_sel_o == m_sel, {tag, " R2 sel"}, freq_sel_o, m_sel);
    chk(sys_rst_o == (m_pc != 0), {tag, " R9 rst"}, sys_rst_o, m_pc != 0);
    read(2'd1, v);
    chk(v == exp_rd(2'd1), {tag, " R6 ctl"}, v, exp_rd(2'd1));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin step(0, 2'd0, 8'd0); check_model("idle"); end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    read(2'd0, v); chk(v == 8'd0, "R1 sel", v, 0);
    read(2'd1, v); chk(v == 8'd0, "R1 ctl", v, 0);
    chk(sys_rst_o == 1'b0, "R1 rst", sys_rst_o, 0);

    // R2 plain write
    step(1, 2'd0, 8'd3);
    chk(freq_sel_o == 4'd3, "R2 write", freq_sel_o, 3);
    read(2'd0, v); chk(v == 8'd3, "R2 readback", v, 3);

    // R3 disabled: changes never expire
    step(1, 2'd0, 8'd6);
    idle(30);
    read(2'd1, v); chk(v[3] == 1'b0, "R3 no timeout", v[3], 0);

    // R4 same-value write does not start
    step(1, 2'd1, 8'h03);
    step(1, 2'd0, 8'd6);
    idle(RL + 5);
    read(2'd1, v); chk(v[3] == 1'b0, "R4 same value", v[3], 0);
    // R4 exact timing
    step(1, 2'd0, 8'd7);
    idle(RL);
    read(2'd1, v); chk(v[3] == 1'b0, "R4 not early", v[3], 0);
    step(0, 2'd0, 8'd0);
    read(2'd1, v); chk(v[4:3] == 2'b11, "R4 flag+lock", v[4:3], 3);
    chk(freq_sel_o == 4'(REC), "R4 recovery", freq_sel_o, REC);
    // R9 pulse of LEN cycles
    chk(sys_rst_o == 1'b1, "R9 pulse start", sys_rst_o, 1);
    idle(LEN - 1);
    chk(sys_rst_o == 1'b1, "R9 pulse tail", sys_rst_o, 1);
    idle(1);
    chk(sys_rst_o == 1'b0, "R9 pulse end", sys_rst_o, 0);

    // R7 locked ignores select writes
    step(1, 2'd0, 8'd2);
    chk(freq_sel_o == 4'(REC), "R7 locked", freq_sel_o, REC);
    check_model("R7");

    // R6 write 0 keeps, write 1 clears
    step(1, 2'd1, 8'h03);
    read(2'd1, v); chk(v[3] == 1'b1, "R6 write0", v[3], 1);
    step(1, 2'd1, 8'h0B);
    read(2'd1, v); chk(v[4:3] == 2'b10, "R6 clear", v[4:3], 2);

    // R8 unlock by clearing enable
    step(1, 2'd1, 8'h00);
    step(0, 2'd0, 8'd0);
    read(2'd1, v); chk(v[4] == 1'b0, "R8 unlocked", v[4], 0);
    step(1, 2'd0, 8'd2);
    chk(freq_sel_o == 4'd2, "R8 writable", freq_sel_o, 2);

    // R5 restart on new change
    step(1, 2'd1, 8'h01);
    step(1, 2'd0, 8'd3);
    idle(RL - 2);
    step(1, 2'd0, 8'd4);
    idle(RL);
    read(2'd1, v); chk(v[3] == 1'b0, "R5 restarted", v[3], 0);
    idle(1);
    read(2'd1, v); chk(v[3] == 1'b1, "R5 late expiry", v[3], 1);
    step(1, 2'd1, 8'h08);
    idle(1);

    // R10 pulse on change, none on same value
    step(1, 2'd1, 8'h04);
    step(1, 2'd0, 8'd9);
    chk(sys_rst_o == 1'b1, "R10 pulse", sys_rst_o, 1);
    idle(LEN);
    chk(sys_rst_o == 1'b0, "R10 end", sys_rst_o, 0);
    step(1, 2'd0, 8'd9);
    chk(sys_rst_o == 1'b0, "R10 same value", sys_rst_o, 0);

    // R11 no pulse when disabled
    step(1, 2'd1, 8'h00);
    step(1, 2'd0, 8'd1);
    chk(sys_rst_o == 1'b0, "R11 no pulse", sys_rst_o, 0);
    check_model("R11");

    // random traffic against bench model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 12)      step(1, 2'd0, 8'($urandom_range(0, 3)));
      else if (r < 20) step(1, 2'd1, {4'd0, 1'($urandom_range(0, 3) == 0),
                                     3'($urandom) | 3'b001});
      else if (r < 22) step(1, 2'd1, 8'($urandom));
      else if (r < 24) step(1, 2'($urandom_range(2, 3)), 8'($urandom));
      else             step(0, 2'($urandom), 8'd0);
      check_model("rand");
      read(2'd0, v); chk(v == exp_rd(2'd0), "rand R7 sel rd", v, exp_rd(2'd0));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule